// File: doc/BRIEF.md
# Two-Phase Conversion Sequencer

This block is the digital control core of a two-pass subranging sampling converter. A rising edge on an asynchronous start input first passes through a synchronizer. It must then stay high for a minimum number of clock cycles before it is accepted. Once a start is accepted, the block pulls an active-low busy flag and puts the input sampler into hold. It then times a coarse phase, which produces the upper 9 bits, followed by a fine phase. At the boundary between the two phases the residue sampler takes over the hold and the input sampler returns to track. The next acquisition therefore overlaps the fine phase.

Late in the fine phase the block copies a 16-bit two's-complement result into an output latch, taking it from a digital stand-in input. Busy is released a fixed number of cycles after that copy. A read port, gated by active-low chip-select and read, presents the latch on a data bus together with a drive-enable for the pad. While both strobes are held low, the latch contents appear continuously. Analog circuitry is not modelled. Every duration is a parameter counted in clock cycles, and the defaults assume a 100 MHz clock.

The sequencer has five states:
- `ST_IDLE`: waiting for a start.
- `ST_QUAL`: measuring the width of the start pulse.
- `ST_PH1`: coarse phase.
- `ST_PH2`: fine phase.
- `ST_ACQ`: remainder of the minimum acquisition window.

Its transitions are:
- IDLE→QUAL on a synchronized rising edge.
- QUAL→IDLE when the start input drops too early.
- QUAL→PH1 when the pulse has lasted long enough.
- PH1→PH2 after `PH1_CYC` cycles.
- PH2→ACQ after `PH2_CYC` cycles.
- ACQ→IDLE after `ACQ_CYC - PH2_CYC` cycles.

Top module: `conv_seq_ctrl`

## Requirements
- R1: A start pulse whose synchronized level stays high for fewer than `QUAL_CYC` cycles is discarded: busy stays high and `start_err` stays low. A pulse high for `QUAL_CYC` cycles or more is accepted.
- R2: For an accepted start, `busy_n` is first low in the cycle after the (`QUAL_CYC`+2)th rising clock edge following the start edge. It then stays low for exactly `PH1_CYC + PH2_CYC` cycles.
- R3: `in_hold` is 1 (hold) exactly during the `PH1_CYC` cycles starting with the cycle in which busy falls. `ph1_strobe` is a one-cycle pulse in the first of those cycles.
- R4: In the cycle after the coarse phase ends, `in_hold` returns to 0 (track) and `res_hold` becomes 1 for exactly `PH2_CYC` cycles. `ph2_strobe` is a one-cycle pulse in the first of those cycles.
- R5: The latch captures `sample_code` at a single edge. The new value is visible exactly `LEAD_CYC` cycles before `busy_n` rises. Changes to `sample_code` at any other time do not alter the latch.
- R6: The latch holds a 16-bit two's-complement value (bit 15 is the sign) and keeps it unchanged until the next capture.
- R7: `data_drive` is 1 exactly when `cs_n` and `rd_n` are both 0. `data_out` equals the latch in that case and is 0 otherwise. With both strobes held low, `data_out` follows every latch update.
- R8: After busy rises, a new start is refused until `ACQ_CYC` cycles have elapsed since the fine phase began. A start whose synchronized edge falls in the last cycle of `ST_ACQ` is refused, and one a cycle later is accepted.
- R9: A synchronized start edge in `ST_PH1`, `ST_PH2` or `ST_ACQ` leaves the conversion timing unchanged and sets `start_err`. The flag is sticky and only reset clears it.
- R10: During and after reset, `busy_n`=1, `in_hold`=0, `res_hold`=0, both strobes are 0, `start_err`=0 and the latch is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start | input | 1 | Asynchronous start request, rising edge |
| sample_code | input | 16 | Stand-in conversion result, two's complement |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| busy_n | output | 1 | Low while a conversion runs |
| in_hold | output | 1 | Input sampler: 1 hold, 0 track |
| res_hold | output | 1 | Residue sampler: 1 hold, 0 track |
| ph1_strobe | output | 1 | One-cycle start of coarse phase |
| ph2_strobe | output | 1 | One-cycle start of fine phase |
| start_err | output | 1 | Sticky: start arrived while not ready |
| data_out | output | 16 | Read data, 0 when not driven |
| data_drive | output | 1 | Pad output enable for the data bus |

## Verification
Two events can land in the same cycle: the end of the acquisition window and the detection of a new start edge. The bench observes the cycle in which busy rises and counts from there. It places a start edge so that the synchronized edge falls either in the last `ST_ACQ` cycle or one cycle later. The first case must produce no busy and must set the error flag; the second must produce a normal conversion with the flag clear. A second coincidence is a continuous read during the latch update. The bench checks cycle by cycle that the bus changes from the old code to the new one exactly `LEAD_CYC` cycles before busy rises, and that a later change on `sample_code` does not reach the bus.

// File: rtl/cseq_pkg.sv
package cseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_QUAL = 3'd1,
        ST_PH1  = 3'd2,
        ST_PH2  = 3'd3,
        ST_ACQ  = 3'd4
    } cseq_state_t;

    function automatic int cseq_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cseq_sync.sv
module cseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[0] <= 1'b0;
                else        chain_q[0] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= 1'b0;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign level = chain_q[STAGES-1];
    assign rise  = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/cseq_fsm.sv
module cseq_fsm
    import cseq_pkg::*;
#(
    parameter int QUAL_CYC = 5,
    parameter int PH1_CYC  = 340,
    parameter int PH2_CYC  = 180,
    parameter int LEAD_CYC = 4,
    parameter int ACQ_CYC  = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_lvl,
    input  logic start_rise,
    output logic busy_n,
    output logic in_hold,
    output logic res_hold,
    output logic ph1_strobe,
    output logic ph2_strobe,
    output logic load,
    output logic start_err
);
    localparam int TAIL_CYC = (ACQ_CYC > PH2_CYC) ? (ACQ_CYC - PH2_CYC) : 1;
    localparam int MAX_CYC  = cseq_max(cseq_max(PH1_CYC, PH2_CYC), cseq_max(TAIL_CYC, QUAL_CYC));
    localparam int CNT_W    = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] QUAL_LAST = CNT_W'(QUAL_CYC - 1);
    localparam logic [CNT_W-1:0] PH1_LAST  = CNT_W'(PH1_CYC - 1);
    localparam logic [CNT_W-1:0] PH2_LAST  = CNT_W'(PH2_CYC - 1);
    localparam logic [CNT_W-1:0] TAIL_LAST = CNT_W'(TAIL_CYC - 1);
    localparam logic [CNT_W-1:0] LOAD_AT   = CNT_W'(PH2_CYC - LEAD_CYC - 1);

    cseq_state_t       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              err_q;
    logic              not_ready;

    // next-state selection
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (start_rise) begin
                    state_d = ST_QUAL;
                    cnt_d   = CNT_W'(1);
                end
            end
            ST_QUAL: begin
                if (!start_lvl) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else if (cnt_q >= QUAL_LAST) begin
                    state_d = ST_PH1;
                    cnt_d   = '0;
                end
            end
            ST_PH1: begin
                if (cnt_q == PH1_LAST) begin
                    state_d = ST_PH2;
                    cnt_d   = '0;
                end
            end
            ST_PH2: begin
                if (cnt_q == PH2_LAST) begin
                    state_d = ST_ACQ;
                    cnt_d   = '0;
                end
            end
            ST_ACQ: begin
                if (cnt_q == TAIL_LAST) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    assign not_ready = (state_q == ST_PH1) || (state_q == ST_PH2) || (state_q == ST_ACQ);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (start_rise && not_ready) err_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy_n     = 1'b1;
        in_hold    = 1'b0;
        res_hold   = 1'b0;
        ph1_strobe = 1'b0;
        ph2_strobe = 1'b0;
        load       = 1'b0;
        unique case (state_q)
            ST_PH1: begin
                busy_n     = 1'b0;
                in_hold    = 1'b1;
                ph1_strobe = (cnt_q == '0);
            end
            ST_PH2: begin
                busy_n     = 1'b0;
                res_hold   = 1'b1;
                ph2_strobe = (cnt_q == '0);
                load       = (cnt_q == LOAD_AT);
            end
            ST_IDLE, ST_QUAL, ST_ACQ: ;
            default: ;
        endcase
    end

    assign start_err = err_q;

    AST_HOLD_AT_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_n) |-> (in_hold && ph1_strobe && !res_hold)); // R3
    AST_TRACK_AT_PH2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_hold) |-> ($fell(in_hold) && ph2_strobe)); // R4
    AST_LOAD_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_n) |-> (!load && $past(res_hold) && !$past(load))); // R5
    AST_ERR_ON_EARLY_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start_rise && !busy_n) |=> start_err); // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start_err) |-> start_err); // R9

endmodule

// File: rtl/cseq_latch.sv
module cseq_latch #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] sample,
    input  logic         cs_n,
    input  logic         rd_n,
    output logic [W-1:0] data_out,
    output logic         data_drive
);
    logic [W-1:0] latch_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    latch_q <= '0;
        else if (load) latch_q <= sample;
    end

    assign data_drive = ~cs_n & ~rd_n;
    assign data_out   = data_drive ? latch_q : '0;

    AST_LATCH_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (latch_q == $past(sample))); // R5
    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(latch_q)); // R6

endmodule

// File: rtl/conv_seq_ctrl.sv
module conv_seq_ctrl #(
    parameter int DATA_W   = 16,
    parameter int SYNC_STG = 2,
    parameter int QUAL_CYC = 5,
    parameter int PH1_CYC  = 340,
    parameter int PH2_CYC  = 180,
    parameter int LEAD_CYC = 4,
    parameter int ACQ_CYC  = 250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_start,
    input  logic [DATA_W-1:0] sample_code,
    input  logic              cs_n,
    input  logic              rd_n,
    output logic              busy_n,
    output logic              in_hold,
    output logic              res_hold,
    output logic              ph1_strobe,
    output logic              ph2_strobe,
    output logic              start_err,
    output logic [DATA_W-1:0] data_out,
    output logic              data_drive
);
    logic start_lvl;
    logic start_rise;
    logic load;

    cseq_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (conv_start),
        .level    (start_lvl),
        .rise     (start_rise)
    );

    cseq_fsm #(
        .QUAL_CYC (QUAL_CYC),
        .PH1_CYC  (PH1_CYC),
        .PH2_CYC  (PH2_CYC),
        .LEAD_CYC (LEAD_CYC),
        .ACQ_CYC  (ACQ_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_lvl  (start_lvl),
        .start_rise (start_rise),
        .busy_n     (busy_n),
        .in_hold    (in_hold),
        .res_hold   (res_hold),
        .ph1_strobe (ph1_strobe),
        .ph2_strobe (ph2_strobe),
        .load       (load),
        .start_err  (start_err)
    );

    cseq_latch #(.W(DATA_W)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .sample     (sample_code),
        .cs_n       (cs_n),
        .rd_n       (rd_n),
        .data_out   (data_out),
        .data_drive (data_drive)
    );

endmodule

// File: tb/sim_conv_seq_ctrl.sv
module sim_conv_seq_ctrl;
    localparam int QUAL = 3;
    localparam int PH1  = 12;
    localparam int PH2  = 8;
    localparam int LEAD = 2;
    localparam int ACQ  = 11;
    localparam int TAIL = ACQ - PH2;
    localparam int TOT  = PH1 + PH2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_start = 1'b0;
    logic [15:0] sample_code = '0;
    logic        cs_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        busy_n, in_hold, res_hold, ph1_strobe, ph2_strobe, start_err, data_drive;
    logic [15:0] data_out;

    int n_run = 0;
    int n_fail = 0;
    logic [15:0] prev = '0;

    always #2 clk = ~clk;

    conv_seq_ctrl #(
        .DATA_W(16), .SYNC_STG(2), .QUAL_CYC(QUAL), .PH1_CYC(PH1),
        .PH2_CYC(PH2), .LEAD_CYC(LEAD), .ACQ_CYC(ACQ)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .sample_code(sample_code),
        .cs_n(cs_n), .rd_n(rd_n), .busy_n(busy_n), .in_hold(in_hold), .res_hold(res_hold),
        .ph1_strobe(ph1_strobe), .ph2_strobe(ph2_strobe), .start_err(start_err),
        .data_out(data_out), .data_drive(data_drive)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        conv_start = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 busy_n in reset", int'(busy_n), 1);
        rst_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0;
        #1;
        chk("R10 busy_n", int'(busy_n), 1);
        chk("R10 in_hold", int'(in_hold), 0);
        chk("R10 res_hold", int'(res_hold), 0);
        chk("R10 strobes", int'({ph1_strobe, ph2_strobe}), 0);
        chk("R10 start_err", int'(start_err), 0);
        chk("R10 latch", int'(data_out), 0);
        prev = '0;
    endtask

    // one conversion; returns at the first negedge with busy high again
    task automatic run_conv(input logic [15:0] code, input int width, input int intrude);
        int ok_pre;
        ok_pre = 1;
        sample_code = code; cs_n = 1'b0; rd_n = 1'b0;
        conv_start = 1'b1;
        for (int k = 1; k <= QUAL + 2; k++) begin
            @(negedge clk);
            if (k == width) conv_start = 1'b0;
            if (k <= QUAL + 1 && busy_n != 1'b1) ok_pre = 0;
        end
        chk("R2 busy high before acceptance", ok_pre, 1);
        chk("R2 busy falls at edge QUAL+2", int'(busy_n), 0);
        for (int idx = 0; idx <= TOT; idx++) begin
            if (idx > 0) @(negedge clk);
            chk("R2 busy_n window", int'(busy_n), (idx >= TOT) ? 1 : 0);
            chk("R3 in_hold", int'(in_hold), (idx < PH1) ? 1 : 0);
            chk("R3 ph1_strobe", int'(ph1_strobe), (idx == 0) ? 1 : 0);
            chk("R4 res_hold", int'(res_hold), (idx >= PH1 && idx < TOT) ? 1 : 0);
            chk("R4 ph2_strobe", int'(ph2_strobe), (idx == PH1) ? 1 : 0);
            chk("R5 R7 bus during conversion", int'(data_out),
                int'((idx >= TOT - LEAD) ? code : prev));
            if (idx == TOT - LEAD) sample_code = ~code;
            if (idx == intrude) conv_start = 1'b1;
            if (intrude >= 0 && idx == intrude + QUAL + 1) conv_start = 1'b0;
        end
        chk("R6 signed value", int'($signed(data_out)),
            (int'(code) >= 32768) ? int'(code) - 65536 : int'(code));
        prev = code;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int ok;
        do_reset();

        // sweep of codes incl. extremes
        run_conv(16'h7FFF, QUAL + 2, -1); repeat (TAIL) @(negedge clk);
        run_conv(16'h8000, QUAL + 2, -1); repeat (TAIL) @(negedge clk);
        run_conv(16'hFFFF, QUAL + 2, -1); repeat (TAIL) @(negedge clk);
        run_conv(16'h0001, QUAL + 2, -1); repeat (TAIL) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            run_conv(16'((i * 16'h2469) ^ 16'hA5A5), QUAL + 2, -1);
            repeat (TAIL) @(negedge clk);
        end
        chk("R9 no error after clean runs", int'(start_err), 0);

        // bus strobe combinations
        for (int c = 0; c < 4; c++) begin
            cs_n = c[0]; rd_n = c[1];
            #1;
            chk("R7 data_drive", int'(data_drive), (c == 0) ? 1 : 0);
            chk("R7 data_out", int'(data_out), (c == 0) ? int'(prev) : 0);
            @(negedge clk);
        end
        cs_n = 1'b0; rd_n = 1'b0;

        // short pulse discarded
        conv_start = 1'b1;
        repeat (QUAL - 1) @(negedge clk);
        conv_start = 1'b0;
        ok = 1;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (busy_n != 1'b1) ok = 0;
        end
        chk("R1 short pulse no busy", ok, 1);
        chk("R1 short pulse no error", int'(start_err), 0);
        chk("R1 latch kept", int'(data_out), int'(prev));

        // minimum width accepted
        run_conv(16'h4C3B, QUAL, -1);
        chk("R1 minimum width accepted", int'(start_err), 0);

        // start one cycle after the acquisition tail: accepted
        repeat (TAIL - 2) @(negedge clk);
        run_conv(16'h1357, QUAL + 2, -1);
        chk("R8 start right after tail accepted", int'(start_err), 0);
        repeat (TAIL) @(negedge clk);

        // start during conversion: ignored, flagged
        run_conv(16'hBEEF, QUAL + 2, 3);
        chk("R9 early start flagged", int'(start_err), 1);
        repeat (TAIL + 10) @(negedge clk);
        chk("R9 flag sticky", int'(start_err), 1);
        chk("R9 no extra conversion", int'(busy_n), 1);

        do_reset();

        // start edge in last tail cycle: refused
        run_conv(16'h2222, QUAL + 2, -1);
        repeat (TAIL - 3) @(negedge clk);
        sample_code = 16'h5555;
        conv_start = 1'b1;
        ok = 1;
        for (int k = 1; k <= QUAL + 8; k++) begin
            @(negedge clk);
            if (k == QUAL + 2) conv_start = 1'b0;
            if (busy_n != 1'b1) ok = 0;
        end
        chk("R8 start in last tail cycle refused", ok, 1);
        chk("R8 refused start flagged", int'(start_err), 1);
        chk("R8 latch unchanged", int'(data_out), 16'h2222);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule